// File: doc/BRIEF.md
# Event-to-Counter Binding Table

This block keeps the association between a small set of hardware event identifiers and the programmable performance counters that count them. Software binds an event to a counter by writing an event-select value for that counter. Software unbinds every event from a counter by writing zero to that counter's event-select. Writes that name an unusable counter or an event outside the supported set are refused, and an error strobe is raised for them.

At run time, event strobes arrive with their identifier. The table returns the bound counter index and a hit flag, and it turns these into a one-hot increment enable for the counter bank. An increment enable is raised only when the bound counter is not inhibited. Two query outputs report whether a given counter index is counting cycles or retired instructions. The fixed cycle counter and the fixed instruction counter always count as such.

Top module: `evt_bind_table`

## Requirements
- R1: The event identifier of a write is bits 19:0 of `wr_value`. Bits above 19 have no effect on which event is bound.
- R2: Only these identifiers can be bound: 0x00001 (cycles), 0x00002 (instructions), 0x10019 (data TLB read miss), 0x1001B (data TLB write miss) and 0x10021 (instruction TLB miss). Within these, bits 19:16 are the type, and a cache-type code carries a cache id in bits 15:3, an operation in bits 2:1 and a result in bit 0. A non-zero write that carries any other identifier is rejected and leaves the table unchanged. This includes a non-zero write whose identifier is zero.
- R3: A write of zero to a usable counter removes every binding that points at that counter. It raises no error.
- R4: A write for an identifier that is already bound is accepted without error and leaves the existing binding unchanged.
- R5: A write to a counter index below `FIRST_PROG`, or at or above `FIRST_PROG+NUM_PROG`, is rejected and changes nothing.
- R6: With `evt_vld` high and a bound identifier on `evt_id`, `evt_hit` is 1 and `evt_ctr` gives the bound counter in the same cycle. In every other case both outputs are 0.
- R7: `inc_en` has exactly the bit of `evt_ctr` set when `evt_hit` is 1 and that counter's `inhibit` bit is 0. Otherwise `inc_en` is all zero.
- R8: `qry_is_cycles` is 1 for counter 0, and for the counter bound to the cycle event.
- R9: `qry_is_instr` is 1 for counter 2, and for the counter bound to the instruction event.
- R10: `wr_err` is high for exactly the one cycle after a rejected write. A table change becomes visible in the cycle after the write.
- R11: After reset no event is bound and `wr_err` is 0.
- R12: Binding a second event to a counter that already has one adds the binding. Both events then hit that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Event-select write strobe |
| wr_ctr | input | CTR_IDX_W | Counter whose event-select is written |
| wr_value | input | SEL_W | Written event-select value |
| wr_err | output | 1 | One-cycle pulse for a rejected write |
| evt_vld | input | 1 | Event strobe |
| evt_id | input | 20 | Identifier of the strobed event |
| inhibit | input | 2**CTR_IDX_W | Per-counter inhibit mask |
| evt_hit | output | 1 | Strobed event is bound |
| evt_ctr | output | CTR_IDX_W | Counter bound to the strobed event |
| inc_en | output | 2**CTR_IDX_W | One-hot increment enable |
| qry_ctr | input | CTR_IDX_W | Counter index being queried |
| qry_is_cycles | output | 1 | Queried counter counts cycles |
| qry_is_instr | output | 1 | Queried counter counts instructions |

## Verification
The bench writes the cycle event a second time to a different counter. A design that let the second write win would move the cycle count onto the new counter. It sends non-zero values whose low 20 bits are zero, or whose upper bits are all ones. A design that tested the whole word, or compared the full value against the supported set, would bind nothing or raise the wrong error. It unbinds a counter that holds two events, and also a counter that holds none. A table that cleared only one entry, or flagged the empty unbind, would fail the lookups or raise `wr_err` there. It also drives counter indices just outside the programmable range, and holds lookups on inhibited counters. An off-by-one range check, or an enable that ignores `inhibit`, would show up as a wrong error strobe or as a stray increment bit.

// File: rtl/evt_bind_pkg.sv
package evt_bind_pkg;

   localparam int EVT_ID_W  = 20;
   localparam int EVT_SLOTS = 5;

   typedef logic [EVT_ID_W-1:0] evt_id_t;

   // slot numbering; the cycle and instruction slots feed the queries
   localparam int SLOT_CYC     = 0;
   localparam int SLOT_INS     = 1;
   localparam int SLOT_DTLB_RD = 2;
   localparam int SLOT_DTLB_WR = 3;
   localparam int SLOT_ITLB    = 4;

   // identifier fields
   typedef struct packed {
      logic [3:0]  kind;
      logic [12:0] cache;
      logic [1:0]  op;
      logic        res;
   } cache_evt_t;

   localparam logic [3:0]  KIND_HW    = 4'h0;
   localparam logic [3:0]  KIND_CACHE = 4'h1;
   localparam logic [12:0] CACHE_DTLB = 13'd3;
   localparam logic [12:0] CACHE_ITLB = 13'd4;
   localparam logic [1:0]  OP_READ    = 2'd0;
   localparam logic [1:0]  OP_WRITE   = 2'd1;
   localparam logic        RES_MISS   = 1'b1;
   localparam logic [15:0] HW_CYCLES  = 16'h0001;
   localparam logic [15:0] HW_INSTR   = 16'h0002;

   function automatic logic [EVT_SLOTS-1:0] slot_onehot(evt_id_t id);
      cache_evt_t f;
      logic [EVT_SLOTS-1:0] oh;
      f  = id;
      oh = '0;
      if (f.kind == KIND_HW) begin
         oh[SLOT_CYC] = (id[15:0] == HW_CYCLES);
         oh[SLOT_INS] = (id[15:0] == HW_INSTR);
      end else if (f.kind == KIND_CACHE && f.res == RES_MISS) begin
         oh[SLOT_DTLB_RD] = (f.cache == CACHE_DTLB) && (f.op == OP_READ);
         oh[SLOT_DTLB_WR] = (f.cache == CACHE_DTLB) && (f.op == OP_WRITE);
         oh[SLOT_ITLB]    = (f.cache == CACHE_ITLB) && (f.op == OP_READ);
      end
      return oh;
   endfunction

endpackage

// File: rtl/evt_id_decode.sv
module evt_id_decode
   import evt_bind_pkg::*;
(
   input  evt_id_t              id,
   output logic [EVT_SLOTS-1:0] slot_oh,
   output logic                 known
);
   always_comb begin
      slot_oh = slot_onehot(id);
      known   = |slot_oh;
   end
endmodule

// File: rtl/evt_bind_entry.sv
module evt_bind_entry #(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set,
   input  logic [IDX_W-1:0] set_ctr,
   input  logic             unbind,
   input  logic [IDX_W-1:0] unbind_ctr,
   output logic             vld,
   output logic [IDX_W-1:0] idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
         idx <= '0;
      end else if (set) begin
         vld <= 1'b1;
         idx <= set_ctr;
      end else if (unbind && vld && idx == unbind_ctr) begin
         vld <= 1'b0;
         idx <= '0;
      end
   end
endmodule

// File: rtl/evt_ctr_gate.sv
module evt_ctr_gate #(
   parameter int IDX_W      = 5,
   parameter int FIRST_PROG = 3,
   parameter int NUM_PROG   = 8
) (
   input  logic [IDX_W-1:0]      wr_ctr,
   output logic                  wr_ctr_ok,
   input  logic                  hit,
   input  logic [IDX_W-1:0]      hit_ctr,
   input  logic [(1<<IDX_W)-1:0] inhibit,
   output logic [(1<<IDX_W)-1:0] inc_en
);
   localparam int NCTR = 1 << IDX_W;

   logic [NCTR-1:0] avail;
   logic [NCTR-1:0] sel;

   for (genvar c = 0; c < NCTR; c++) begin : g_ctr
      if (c >= FIRST_PROG && c < FIRST_PROG + NUM_PROG) begin : g_prog
         assign avail[c] = 1'b1;
      end else begin : g_fixed
         assign avail[c] = 1'b0;
      end
      assign sel[c] = (hit_ctr == IDX_W'(c));
   end

   assign wr_ctr_ok = avail[wr_ctr];
   assign inc_en    = hit ? (sel & avail & ~inhibit) : '0;
endmodule

// File: rtl/evt_bind_table.sv
module evt_bind_table
   import evt_bind_pkg::*;
#(
   parameter int SEL_W         = 64,
   parameter int CTR_IDX_W     = 5,
   parameter int FIRST_PROG    = 3,
   parameter int NUM_PROG      = 8,
   parameter int FIXED_CYC_CTR = 0,
   parameter int FIXED_INS_CTR = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [CTR_IDX_W-1:0]      wr_ctr,
   input  logic [SEL_W-1:0]          wr_value,
   output logic                      wr_err,
   input  logic                      evt_vld,
   input  logic [EVT_ID_W-1:0]       evt_id,
   input  logic [(1<<CTR_IDX_W)-1:0] inhibit,
   output logic                      evt_hit,
   output logic [CTR_IDX_W-1:0]      evt_ctr,
   output logic [(1<<CTR_IDX_W)-1:0] inc_en,
   input  logic [CTR_IDX_W-1:0]      qry_ctr,
   output logic                      qry_is_cycles,
   output logic                      qry_is_instr
);
   localparam int NUM_CTR = 1 << CTR_IDX_W;
   localparam logic [CTR_IDX_W-1:0] CYC_FIX = CTR_IDX_W'(FIXED_CYC_CTR);
   localparam logic [CTR_IDX_W-1:0] INS_FIX = CTR_IDX_W'(FIXED_INS_CTR);

   if (SEL_W < EVT_ID_W) begin : g_bad_sel
      $error("SEL_W narrower than the event identifier");
   end
   if (NUM_PROG < 1 || FIRST_PROG + NUM_PROG > NUM_CTR) begin : g_bad_prog
      $error("programmable counter range does not fit the index width");
   end
   if (FIXED_CYC_CTR >= FIRST_PROG || FIXED_INS_CTR >= FIRST_PROG) begin : g_bad_fixed
      $error("fixed counters must lie below the programmable range");
   end

   // write path
   logic [EVT_SLOTS-1:0] wr_oh;
   logic                 wr_known;
   logic                 wr_ctr_ok;
   logic                 wr_zero;
   logic                 wr_dup;
   logic                 wr_reject;
   logic                 wr_unbind;
   logic [EVT_SLOTS-1:0] wr_set;

   // table state
   logic [EVT_SLOTS-1:0] ent_vld;
   logic [CTR_IDX_W-1:0] ent_idx [EVT_SLOTS];

   // lookup path
   logic [EVT_SLOTS-1:0] lk_oh;
   logic                 lk_known;

   evt_id_decode u_wr_dec (
      .id      (wr_value[EVT_ID_W-1:0]),
      .slot_oh (wr_oh),
      .known   (wr_known)
   );

   evt_id_decode u_lk_dec (
      .id      (evt_id),
      .slot_oh (lk_oh),
      .known   (lk_known)
   );

   evt_ctr_gate #(
      .IDX_W      (CTR_IDX_W),
      .FIRST_PROG (FIRST_PROG),
      .NUM_PROG   (NUM_PROG)
   ) u_gate (
      .wr_ctr    (wr_ctr),
      .wr_ctr_ok (wr_ctr_ok),
      .hit       (evt_hit),
      .hit_ctr   (evt_ctr),
      .inhibit   (inhibit),
      .inc_en    (inc_en)
   );

   always_comb begin
      wr_zero   = (wr_value == '0);
      wr_dup    = |(wr_oh & ent_vld);
      wr_reject = wr_en && (!wr_ctr_ok || (!wr_zero && !wr_dup && !wr_known));
      wr_unbind = wr_en && wr_ctr_ok && wr_zero;
      wr_set    = (wr_en && wr_ctr_ok && !wr_zero && !wr_dup) ? wr_oh : '0;
   end

   for (genvar s = 0; s < EVT_SLOTS; s++) begin : g_slot
      evt_bind_entry #(.IDX_W(CTR_IDX_W)) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .set        (wr_set[s]),
         .set_ctr    (wr_ctr),
         .unbind     (wr_unbind),
         .unbind_ctr (wr_ctr),
         .vld        (ent_vld[s]),
         .idx        (ent_idx[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_err <= 1'b0;
      else        wr_err <= wr_reject;
   end

   always_comb begin
      evt_ctr = '0;
      for (int s = 0; s < EVT_SLOTS; s++) begin
         if (evt_vld && lk_oh[s] && ent_vld[s]) evt_ctr = evt_ctr | ent_idx[s];
      end
      evt_hit = evt_vld && lk_known && |(lk_oh & ent_vld);
   end

   always_comb begin
      qry_is_cycles = (qry_ctr == CYC_FIX) ||
                      (ent_vld[SLOT_CYC] && ent_idx[SLOT_CYC] == qry_ctr &&
                       ent_idx[SLOT_CYC] != '0);
      qry_is_instr  = (qry_ctr == INS_FIX) ||
                      (ent_vld[SLOT_INS] && ent_idx[SLOT_INS] == qry_ctr &&
                       ent_idx[SLOT_INS] != '0);
   end

endmodule

// File: rtl/evt_bind_checker.sv
module evt_bind_checker
   import evt_bind_pkg::*;
#(
   parameter int SEL_W      = 64,
   parameter int CTR_IDX_W  = 5,
   parameter int FIRST_PROG = 3,
   parameter int NUM_PROG   = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_en,
   input logic [CTR_IDX_W-1:0]      wr_ctr,
   input logic [SEL_W-1:0]          wr_value,
   input logic                      wr_err,
   input logic                      evt_vld,
   input logic [EVT_ID_W-1:0]       evt_id,
   input logic [(1<<CTR_IDX_W)-1:0] inhibit,
   input logic                      evt_hit,
   input logic [CTR_IDX_W-1:0]      evt_ctr,
   input logic [(1<<CTR_IDX_W)-1:0] inc_en,
   input logic [CTR_IDX_W-1:0]      qry_ctr,
   input logic                      qry_is_cycles,
   input logic                      qry_is_instr
);
   localparam logic [CTR_IDX_W:0] LO_L = (CTR_IDX_W+1)'(FIRST_PROG);
   localparam logic [CTR_IDX_W:0] HI_L = (CTR_IDX_W+1)'(FIRST_PROG + NUM_PROG);

   logic ctr_usable;
   assign ctr_usable = ({1'b0, wr_ctr} >= LO_L) && ({1'b0, wr_ctr} < HI_L);

   p_err_follows_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en));

   p_bad_ctr_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ctr_usable) |=> wr_err);

   p_unbind_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ctr_usable && wr_value == '0) |=> !wr_err);

   p_inc_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(inc_en));

   p_inc_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|inc_en) |-> (evt_hit && evt_vld));

   p_no_inhibited_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en & inhibit) == '0);

   p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_hit |-> (evt_ctr == '0));

   p_lookup_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && evt_vld && $past(evt_vld) && $stable(evt_id))
         |-> ($stable(evt_hit) && $stable(evt_ctr)));

endmodule

bind evt_bind_table evt_bind_checker #(
   .SEL_W      (SEL_W),
   .CTR_IDX_W  (CTR_IDX_W),
   .FIRST_PROG (FIRST_PROG),
   .NUM_PROG   (NUM_PROG)
) u_evt_bind_checker (.*);

// File: tb/test_evt_bind_table.sv
module test_evt_bind_table;
   localparam int SEL_W = 64;
   localparam int IW    = 5;
   localparam int NC    = 1 << IW;
   localparam int FP    = 3;
   localparam int NP    = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [IW-1:0]   wr_ctr = '0;
   logic [SEL_W-1:0] wr_value = '0;
   logic            wr_err;
   logic            evt_vld = 1'b0;
   logic [19:0]     evt_id = '0;
   logic [NC-1:0]   inhibit = '0;
   logic            evt_hit;
   logic [IW-1:0]   evt_ctr;
   logic [NC-1:0]   inc_en;
   logic [IW-1:0]   qry_ctr = '0;
   logic            qry_is_cycles;
   logic            qry_is_instr;

   always #2 clk = ~clk;

   evt_bind_table #(.SEL_W(SEL_W), .CTR_IDX_W(IW), .FIRST_PROG(FP), .NUM_PROG(NP))
   i_evt_bind_table (.*);

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   string phase = "R11 reset";

   // behavioural reference
   int m_vld [5];
   int m_idx [5];
   bit m_err = 1'b0;

   function automatic int slot_of(logic [19:0] id);
      case (id)
         20'h00001: return 0;
         20'h00002: return 1;
         20'h10019: return 2;
         20'h1001B: return 3;
         20'h10021: return 4;
         default:   return -1;
      endcase
   endfunction

   task automatic model_write();
      int c;
      int s;
      c = int'(wr_ctr);
      m_err = 1'b0;
      if (!wr_en) return;
      if (c < FP || c >= FP + NP) begin
         m_err = 1'b1;
      end else if (wr_value == '0) begin
         for (int k = 0; k < 5; k++)
            if (m_vld[k] != 0 && m_idx[k] == c) begin m_vld[k] = 0; m_idx[k] = 0; end
      end else begin
         s = slot_of(wr_value[19:0]);
         if (s < 0) m_err = 1'b1;
         else if (m_vld[s] == 0) begin m_vld[s] = 1; m_idx[s] = c; end
      end
   endtask

   task automatic cmp(string tag, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
      end
   endtask

   task automatic check_now();
      int s;
      bit hit;
      int ctr;
      logic [NC-1:0] inc;
      int q;
      s   = slot_of(evt_id);
      hit = evt_vld && s >= 0 && m_vld[s] != 0;
      ctr = hit ? m_idx[s] : 0;
      inc = '0;
      if (hit && !inhibit[ctr]) inc[ctr] = 1'b1;
      q = int'(qry_ctr);
      cmp("R6 evt_hit", longint'(evt_hit), longint'(hit));
      cmp("R6 evt_ctr", longint'(evt_ctr), longint'(ctr));
      cmp("R7 inc_en", longint'(inc_en), longint'(inc));
      cmp("R8 qry_is_cycles", longint'(qry_is_cycles),
          longint'(q == 0 || (m_vld[0] != 0 && m_idx[0] == q)));
      cmp("R9 qry_is_instr", longint'(qry_is_instr),
          longint'(q == 2 || (m_vld[1] != 0 && m_idx[1] == q)));
      cmp("R10 wr_err", longint'(wr_err), longint'(m_err));
   endtask

   task automatic cyc(input bit we, input int c, input logic [SEL_W-1:0] v,
                      input bit ev, input logic [19:0] id,
                      input logic [NC-1:0] inh, input int q);
      wr_en = we; wr_ctr = IW'(c); wr_value = v;
      evt_vld = ev; evt_id = id; inhibit = inh; qry_ctr = IW'(q);
      @(negedge clk);
      model_write();
      check_now();
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog [%s] actual=hung expected=done", phase);
         finish_run();
      end
   end

   initial begin
      logic [31:0] lf;
      logic [19:0] rid;
      for (int k = 0; k < 5; k++) begin m_vld[k] = 0; m_idx[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: nothing bound after reset
      cyc(0, 0, '0, 1, 20'h00001, '0, 3);
      cyc(0, 0, '0, 1, 20'h00002, '0, 4);

      phase = "R1 upper bits ignored";
      cyc(1, 3, 64'hFFFF_FFFF_FFF0_0001, 1, 20'h00001, '0, 3);
      phase = "R9 instr bind";
      cyc(1, 4, 64'h2, 1, 20'h00002, '0, 4);
      cyc(0, 0, '0, 1, 20'h00002, '0, 2);
      phase = "R12 two events one counter";
      cyc(1, 5, 64'h10019, 1, 20'h10019, '0, 5);
      cyc(1, 5, 64'h1001B, 1, 20'h1001B, '0, 5);
      cyc(0, 0, '0, 1, 20'h10019, '0, 5);
      phase = "R4 duplicate keeps first";
      cyc(1, 6, 64'h1, 1, 20'h00001, '0, 6);
      cyc(0, 0, '0, 1, 20'h00001, '0, 3);
      phase = "R2 unsupported id";
      cyc(1, 7, 64'h10020, 1, 20'h10020, '0, 7);
      cyc(1, 7, 64'h0010_0000, 1, 20'h00000, '0, 7);
      cyc(1, 7, 64'h10019, 0, 20'h10019, '0, 0);
      phase = "R5 counter range";
      cyc(1, 2, 64'h10021, 1, 20'h10021, '0, 2);
      cyc(1, 11, 64'h10021, 1, 20'h10021, '0, 11);
      cyc(1, 10, 64'h10021, 1, 20'h10021, '0, 10);
      phase = "R7 inhibit";
      cyc(0, 0, '0, 1, 20'h00001, 32'h0000_0008, 3);
      cyc(0, 0, '0, 1, 20'h10021, 32'h0000_0008, 1);
      cyc(0, 0, '0, 0, 20'h10021, '0, 1);
      phase = "R3 unbind";
      cyc(1, 5, '0, 1, 20'h10019, '0, 5);
      cyc(0, 0, '0, 1, 20'h1001B, '0, 5);
      cyc(1, 9, '0, 1, 20'h00001, '0, 9);
      cyc(1, 3, '0, 1, 20'h00001, '0, 3);
      cyc(1, 8, 64'h1, 1, 20'h00001, '0, 8);
      cyc(1, 0, '0, 0, 20'h0, '0, 0);

      phase = "mixed traffic R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R12";
      lf = 32'hACE1_2345;
      for (int i = 0; i < 4000; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         case (lf[4:2])
            3'd0: rid = 20'h00001;
            3'd1: rid = 20'h00002;
            3'd2: rid = 20'h10019;
            3'd3: rid = 20'h1001B;
            3'd4: rid = 20'h10021;
            3'd5: rid = lf[27:8];
            default: rid = 20'h0;
         endcase
         cyc(lf[6:5] == 2'b01, int'(lf[12:9]),
             lf[13] ? {44'(lf[31:14]) & {44{lf[7]}}, rid} : {44'h0, rid},
             lf[14], rid, lf[15] ? {lf[19:16], lf[31:4]} : '0,
             int'(lf[20:17]));
      end

      done = 1'b1;
      finish_run();
   end
endmodule